// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds the 256-byte configuration space of one device function. Software reads and writes it in byte, word or dword units at any byte offset. Every byte carries its own write mask, fixed at elaboration. Bits outside the mask keep their reset value, so identity fields, status and the type codes of the address windows stay read-only. Cache-line size, interrupt line, three command bits, the window base fields and the whole device-specific area above offset 0x40 can be written.

Reads are combinational and have no wait states. A wide read that would run past the top of the space is narrowed, first to a word and then to a byte. A wide write near the top is cut off at offset 0xFF and does not wrap. After any write that changes a window base register, or that flips the I/O-decode or memory-decode enable, the block raises a one-cycle pulse so that the address decoders downstream can reload. The window sizes and type codes, the expansion-ROM size and the identity fields are parameters.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset the space holds the default image. Offsets 0x00-0x01 hold the vendor ID and 0x02-0x03 the device ID. Offset 0x08 holds the revision, 0x09-0x0B the 24-bit class code, 0x0E the header type and 0x3D the interrupt pin. Each window holds its type code in its low bits. All other bytes are zero and the remap pulse is low.
- R2: A write of N bytes at offset A puts byte k of the write data (bits 8k+7:8k) into offset A+k, with the least significant byte first. Each byte stores (old & ~mask) | (new & mask), and any alignment is allowed.
- R3: A write whose last byte would fall past 0xFF updates only the bytes up to 0xFF. Offset 0x00 and the rest of the space are left unchanged.
- R4: A dword read returns a full dword only at offsets up to 0xFC. Otherwise it returns a word if the offset is 0xFE or lower, and a single byte if not. A word read at 0xFF returns a byte. Unreturned upper bits are zero.
- R5: Offsets 0x0C and 0x3C are fully writable, and so is every byte from 0x40 to 0xFF. At offset 0x04 only bits 0 (I/O decode), 1 (memory decode) and 2 (bus master) are writable. The identity bytes, status, header type and interrupt pin are read-only.
- R6: Window n sits at offset 0x10+4n, for n from 0 to 5, and is stored little-endian. Its write mask is ~(size-1) for a power-of-two size. Its low bits keep the type code: 1 for an I/O window, 0 for memory. A window of size zero is absent and reads as zero.
- R7: The expansion-ROM window sits at offset 0x30. Its mask is ~(size-1) with bit 0, the ROM enable, also writable. A change to it does not raise the remap pulse.
- R8: The remap pulse is high for exactly the one cycle after a write clock edge, and only when that write changed a byte in 0x10-0x27. A write that leaves those bytes unchanged gives no pulse.
- R9: A write that toggles command bit 0 or bit 1 raises the remap pulse. A write that changes only bit 2 does not.
- R10: Size code 2'b00 selects a byte, 2'b01 a word and 2'b10 a dword. Code 2'b11 is treated as a dword for both reads and writes.
- R11: Read data follows the address and size inputs combinationally. It reflects a write as soon as that write's clock edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the default image |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 8 | Byte offset of the access |
| size | input | 2 | Access width code (see R10) |
| wdata | input | 32 | Write data, least significant byte goes to `addr` |
| rdata | output | 32 | Combinational read data, zero-extended |
| remap_pulse | output | 1 | One-cycle pulse after a window or decode-enable change |

## Verification
Read data needs no clock edge. The bench drives address and size on the falling edge and samples `rdata` 1 ns later, inside the same half cycle. A write takes effect at the next rising edge, and the remap pulse is registered at that same edge. The bench therefore samples the pulse 1 ns after that edge and samples it again one edge later, where it must be low. Any read-back of a written byte is placed on the falling edge after the write edge, which is the first point where the new value is visible.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
   localparam int unsigned SPACE_BYTES = 256;
   localparam int unsigned ADDR_W      = 8;
   localparam int unsigned DATA_BYTES  = 4;
   localparam int unsigned MAX_WIN     = 6;
   localparam int unsigned WIN_BASE    = 16;
   localparam int unsigned WIN_LAST    = WIN_BASE + 4*MAX_WIN - 1;
   localparam int unsigned ROM_BASE    = 48;
   localparam int unsigned CMD_OFS     = 4;
   localparam int unsigned CLS_OFS     = 12;
   localparam int unsigned ILINE_OFS   = 60;
   localparam int unsigned IPIN_OFS    = 61;
   localparam int unsigned HDR_OFS     = 14;
   localparam int unsigned DEVSPEC_OFS = 64;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_DWORD = 2'b10,
      SZ_ALT4  = 2'b11
   } acc_size_e;

   function automatic logic [31:0] win_mask(input logic [4:0] lg);
      return (lg == 5'd0) ? 32'h0 : ~((32'h1 << lg) - 32'h1);
   endfunction

   function automatic logic [31:0] win_reset(input logic [4:0] lg, input logic is_io);
      return (lg != 5'd0 && is_io) ? 32'h1 : 32'h0;
   endfunction
endpackage

// File: rtl/cfg_mask_image.sv
module cfg_mask_image
   import cfg_space_pkg::*;
#(
   parameter logic [MAX_WIN-1:0][4:0] WIN_LOG2  = {5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12},
   parameter logic [MAX_WIN-1:0]      WIN_IS_IO = 6'b000010,
   parameter logic [4:0]              ROM_LOG2  = 5'd16,
   parameter logic [15:0]             VENDOR    = 16'hA5C3,
   parameter logic [15:0]             DEVICE    = 16'h0E71,
   parameter logic [23:0]             CLASS     = 24'h020000,
   parameter logic [7:0]              REVISION  = 8'h03,
   parameter logic [7:0]              HDR_TYPE  = 8'h00,
   parameter logic [7:0]              IRQ_PIN   = 8'h01
) (
   output logic [SPACE_BYTES*8-1:0] mask_img,
   output logic [SPACE_BYTES*8-1:0] rst_img
);
   localparam logic [31:0] ROM_MASK = win_mask(ROM_LOG2) | ((ROM_LOG2 != 5'd0) ? 32'h1 : 32'h0);

   for (genvar w = 0; w < MAX_WIN; w++) begin : g_win_chk
      if (WIN_LOG2[w] != 5'd0 && WIN_LOG2[w] < (WIN_IS_IO[w] ? 5'd2 : 5'd4)) begin : g_bad
         $error("window %0d too small to keep its type code", w);
      end
   end
   if (ROM_LOG2 != 5'd0 && ROM_LOG2 < 5'd11) begin : g_rom_bad
      $error("expansion ROM window below 2 KiB");
   end

   function automatic logic [7:0] mask_of(input int unsigned i);
      if (i == CMD_OFS) return 8'h07;
      if (i == CLS_OFS || i == ILINE_OFS || i >= DEVSPEC_OFS) return 8'hFF;
      if (i >= WIN_BASE && i <= WIN_LAST)
         return 8'(win_mask(WIN_LOG2[(i-WIN_BASE)/4]) >> (8*(i%4)));
      if (i >= ROM_BASE && i < ROM_BASE + 4) return 8'(ROM_MASK >> (8*(i%4)));
      return 8'h00;
   endfunction

   function automatic logic [7:0] reset_of(input int unsigned i);
      case (i)
         0:        return VENDOR[7:0];
         1:        return VENDOR[15:8];
         2:        return DEVICE[7:0];
         3:        return DEVICE[15:8];
         8:        return REVISION;
         9:        return CLASS[7:0];
         10:       return CLASS[15:8];
         11:       return CLASS[23:16];
         HDR_OFS:  return HDR_TYPE;
         IPIN_OFS: return IRQ_PIN;
         default: begin
            if (i >= WIN_BASE && i <= WIN_LAST)
               return 8'(win_reset(WIN_LOG2[(i-WIN_BASE)/4], WIN_IS_IO[(i-WIN_BASE)/4]) >> (8*(i%4)));
            return 8'h00;
         end
      endcase
   endfunction

   for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_byte
      assign mask_img[i*8 +: 8] = mask_of(i);
      assign rst_img[i*8 +: 8]  = reset_of(i);
   end
endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
   import cfg_space_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [2:0]                wlen,
   input  logic [DATA_BYTES*8-1:0]   wdata,
   input  logic [SPACE_BYTES*8-1:0]  mask_img,
   input  logic [SPACE_BYTES*8-1:0]  rst_img,
   output logic [SPACE_BYTES*8-1:0]  cfg_q,
   output logic [SPACE_BYTES*8-1:0]  cfg_d
);
   for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_cell
      localparam logic [ADDR_W:0] IDX = (ADDR_W+1)'(i);
      logic [ADDR_W:0] lane_ofs;
      logic            hit;
      logic [7:0]      lane;
      logic [7:0]      m;

      assign lane_ofs = IDX - {1'b0, addr};
      assign hit      = wr_en && (IDX >= {1'b0, addr}) && (lane_ofs < (ADDR_W+1)'(wlen));
      assign lane     = wdata[8*lane_ofs[1:0] +: 8];
      assign m        = mask_img[i*8 +: 8];
      assign cfg_d[i*8 +: 8] = hit ? ((cfg_q[i*8 +: 8] & ~m) | (lane & m)) : cfg_q[i*8 +: 8];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg_q[i*8 +: 8] <= rst_img[i*8 +: 8];
         else        cfg_q[i*8 +: 8] <= cfg_d[i*8 +: 8];
      end
   end
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
   import cfg_space_pkg::*;
(
   input  logic [ADDR_W-1:0]        addr,
   input  logic [1:0]               size,
   input  logic [SPACE_BYTES*8-1:0] cfg_q,
   output logic [DATA_BYTES*8-1:0]  rdata
);
   logic [2:0] rlen;

   always_comb begin
      if ((size == SZ_DWORD || size == SZ_ALT4) && addr <= 8'hFC) rlen = 3'd4;
      else if (size != SZ_BYTE && addr <= 8'hFE)                  rlen = 3'd2;
      else                                                        rlen = 3'd1;
   end

   for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
      logic [ADDR_W-1:0] idx;
      assign idx = addr + ADDR_W'(k);
      assign rdata[k*8 +: 8] = (3'(k) < rlen) ? cfg_q[{idx, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/cfg_remap_detect.sv
module cfg_remap_detect
   import cfg_space_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [MAX_WIN*32-1:0]     win_q,
   input  logic [MAX_WIN*32-1:0]     win_d,
   input  logic [1:0]                dec_q,
   input  logic [1:0]                dec_d,
   output logic                      remap_pulse
);
   logic changed;
   assign changed = (win_q != win_d) || (dec_q != dec_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) remap_pulse <= 1'b0;
      else        remap_pulse <= changed;
   end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
   import cfg_space_pkg::*;
#(
   parameter logic [MAX_WIN-1:0][4:0] WIN_LOG2  = {5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12},
   parameter logic [MAX_WIN-1:0]      WIN_IS_IO = 6'b000010,
   parameter logic [4:0]              ROM_LOG2  = 5'd16,
   parameter logic [15:0]             VENDOR    = 16'hA5C3,
   parameter logic [15:0]             DEVICE    = 16'h0E71,
   parameter logic [23:0]             CLASS     = 24'h020000,
   parameter logic [7:0]              REVISION  = 8'h03,
   parameter logic [7:0]              HDR_TYPE  = 8'h00,
   parameter logic [7:0]              IRQ_PIN   = 8'h01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  addr,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        remap_pulse
);
   logic [SPACE_BYTES*8-1:0] mask_img, rst_img, cfg_q, cfg_d;
   logic [2:0]               wlen;

   always_comb begin
      case (size)
         SZ_BYTE: wlen = 3'd1;
         SZ_WORD: wlen = 3'd2;
         default: wlen = 3'd4;
      endcase
   end

   cfg_mask_image #(
      .WIN_LOG2(WIN_LOG2), .WIN_IS_IO(WIN_IS_IO), .ROM_LOG2(ROM_LOG2),
      .VENDOR(VENDOR), .DEVICE(DEVICE), .CLASS(CLASS),
      .REVISION(REVISION), .HDR_TYPE(HDR_TYPE), .IRQ_PIN(IRQ_PIN)
   ) u_img (
      .mask_img(mask_img),
      .rst_img (rst_img)
   );

   cfg_byte_store u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wlen(wlen),
      .wdata(wdata), .mask_img(mask_img), .rst_img(rst_img),
      .cfg_q(cfg_q), .cfg_d(cfg_d)
   );

   cfg_read_port u_rd (
      .addr(addr), .size(size), .cfg_q(cfg_q), .rdata(rdata)
   );

   cfg_remap_detect u_remap (
      .clk(clk), .rst_n(rst_n),
      .win_q(cfg_q[WIN_LAST*8+7 : WIN_BASE*8]),
      .win_d(cfg_d[WIN_LAST*8+7 : WIN_BASE*8]),
      .dec_q(cfg_q[CMD_OFS*8 +: 2]),
      .dec_d(cfg_d[CMD_OFS*8 +: 2]),
      .remap_pulse(remap_pulse)
   );
endmodule

// File: rtl/cfg_space_regs_chk.sv
module cfg_space_regs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [7:0]  addr,
   input logic [1:0]  size,
   input logic [31:0] rdata,
   input logic        remap_pulse
);
   // R8
   remap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> $past(wr_en));

   // R4
   top_byte_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 8'hFF) |-> (rdata[31:8] == 24'h0));

   // R4
   top_word_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= 8'hFD) |-> (rdata[31:16] == 16'h0));

   // R10
   byte_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size == 2'b00) |-> (rdata[31:8] == 24'h0));

   // R11
   idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $stable(addr) && $stable(size)) |-> $stable(rdata));

   // R5
   vendor_lo_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 8'h00 && $stable(addr)) |-> (rdata[7:0] == $past(rdata[7:0])));
endmodule

bind cfg_space_regs cfg_space_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
   .rdata(rdata), .remap_pulse(remap_pulse)
);

// File: tb/tb_cfg_space_regs.sv
`timescale 1ns/1ps
module tb_cfg_space_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [1:0]  size = 2'b00;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic        remap_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cfg_space_regs dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
      .wdata(wdata), .rdata(rdata), .remap_pulse(remap_pulse)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  a;
      logic [1:0]  sz;
      logic [31:0] d;
      logic [31:0] exp;
      logic        rm;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 2'b10, 32'h0, 32'h0E71A5C3, 1'b0},    // R1 identity
      '{1'b0, 8'h08, 2'b10, 32'h0, 32'h02000003, 1'b0},    // R1 class/revision
      '{1'b0, 8'h14, 2'b10, 32'h0, 32'h00000001, 1'b0},    // R6 I/O type code
      '{1'b0, 8'h3C, 2'b10, 32'h0, 32'h00000100, 1'b0},    // R1 interrupt pin
      '{1'b1, 8'h00, 2'b10, 32'hFFFFFFFF, 32'h0, 1'b0},    // R5 write to IDs
      '{1'b0, 8'h00, 2'b10, 32'h0, 32'h0E71A5C3, 1'b0},    // R5 IDs unchanged
      '{1'b1, 8'h04, 2'b01, 32'h0000FFFF, 32'h0, 1'b1},    // R9 enable bits set
      '{1'b0, 8'h04, 2'b10, 32'h0, 32'h00000007, 1'b0},    // R5 command mask
      '{1'b1, 8'h04, 2'b00, 32'h00000003, 32'h0, 1'b0},    // R9 master only
      '{1'b0, 8'h04, 2'b00, 32'h0, 32'h00000003, 1'b0},    // R9
      '{1'b1, 8'h10, 2'b10, 32'h12345678, 32'h0, 1'b1},    // R8 window change
      '{1'b0, 8'h10, 2'b10, 32'h0, 32'h12345000, 1'b0},    // R6 memory mask
      '{1'b1, 8'h10, 2'b10, 32'h12345FFF, 32'h0, 1'b0},    // R8 no net change
      '{1'b1, 8'h14, 2'b10, 32'hFFFFFFFF, 32'h0, 1'b1},    // R6 size probe
      '{1'b0, 8'h14, 2'b10, 32'h0, 32'hFFFFFFE1, 1'b0},    // R6
      '{1'b1, 8'h18, 2'b10, 32'hFFFFFFFF, 32'h0, 1'b0},    // R6 absent window
      '{1'b0, 8'h18, 2'b10, 32'h0, 32'h00000000, 1'b0},    // R6
      '{1'b1, 8'h30, 2'b10, 32'hABCDFFFF, 32'h0, 1'b0},    // R7 no remap
      '{1'b0, 8'h30, 2'b10, 32'h0, 32'hABCD0001, 1'b0},    // R7 enable bit kept
      '{1'b1, 8'h3C, 2'b01, 32'h00005A77, 32'h0, 1'b0},    // R5 line + pin
      '{1'b0, 8'h3C, 2'b01, 32'h0, 32'h00000177, 1'b0},    // R5
      '{1'b1, 8'h0C, 2'b00, 32'h000000FF, 32'h0, 1'b0},    // R5 cache line
      '{1'b0, 8'h0C, 2'b10, 32'h0, 32'h000000FF, 1'b0},    // R5
      '{1'b1, 8'h41, 2'b10, 32'h44332211, 32'h0, 1'b0},    // R2 unaligned
      '{1'b0, 8'h40, 2'b10, 32'h0, 32'h33221100, 1'b0},    // R2
      '{1'b0, 8'h44, 2'b00, 32'h0, 32'h00000044, 1'b0},    // R2
      '{1'b1, 8'h80, 2'b11, 32'hCAFEF00D, 32'h0, 1'b0},    // R10 code 11 write
      '{1'b0, 8'h80, 2'b11, 32'h0, 32'hCAFEF00D, 1'b0},    // R10 code 11 read
      '{1'b0, 8'h81, 2'b00, 32'h0, 32'h000000F0, 1'b0},    // R10 byte
      '{1'b0, 8'h80, 2'b01, 32'h0, 32'h0000F00D, 1'b0}     // R10 word
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic do_write(input string req, input logic [7:0] a, input logic [1:0] sz,
                           input logic [31:0] d, input logic rm);
      @(negedge clk);
      wr_en = 1'b1; addr = a; size = sz; wdata = d;
      @(posedge clk);
      #1 check(req, {31'h0, remap_pulse}, {31'h0, rm});
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input string req, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
      @(negedge clk);
      wr_en = 1'b0; addr = a; size = sz;
      #1 check(req, rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check("R1 remap low in reset", {31'h0, remap_pulse}, 32'h0);
      rst_n = 1'b1;
      do_read("R1 ROM window reset", 8'h30, 2'b10, 32'h0);
      do_read("R1 device area reset", 8'h80, 2'b10, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) do_write($sformatf("vector %0d remap", i), VEC[i].a, VEC[i].sz, VEC[i].d, VEC[i].rm);
         else           do_read($sformatf("vector %0d read", i), VEC[i].a, VEC[i].sz, VEC[i].exp);
      end

      // R3 truncation at the top, R4 narrowing
      do_write("R3 top write no remap", 8'hFE, 2'b10, 32'hDDCCBBAA, 1'b0);
      do_read("R3 top dword", 8'hFC, 2'b10, 32'hBBAA0000);
      do_read("R3 no wrap to 0x00", 8'h00, 2'b00, 32'h000000C3);
      do_read("R4 dword at FE as word", 8'hFE, 2'b10, 32'h0000BBAA);
      do_read("R4 dword at FF as byte", 8'hFF, 2'b10, 32'h000000BB);
      do_read("R4 dword at FD as word", 8'hFD, 2'b10, 32'h0000AA00);
      do_read("R4 word at FF as byte", 8'hFF, 2'b01, 32'h000000BB);
      do_write("R3 word at FF", 8'hFF, 2'b01, 32'h00001234, 1'b0);
      do_read("R3 FF updated", 8'hFF, 2'b00, 32'h00000034);
      do_read("R3 00 intact", 8'h00, 2'b01, 32'h0000A5C3);

      // R8 pulse lasts one cycle, last window byte
      do_write("R8 byte in window", 8'h17, 2'b00, 32'h00000000, 1'b1);
      @(posedge clk);
      #1 check("R8 pulse one cycle", {31'h0, remap_pulse}, 32'h0);
      do_read("R6 top byte cleared", 8'h14, 2'b10, 32'h00FFFFE1);

      // R9 memory-decode toggle
      do_write("R9 memory enable off", 8'h04, 2'b00, 32'h00000001, 1'b1);
      do_read("R9 command value", 8'h04, 2'b00, 32'h00000001);

      // R11 visible right after the write edge, combinational address change
      do_write("R11 write", 8'h90, 2'b10, 32'h01020304, 1'b0);
      do_read("R11 read back", 8'h90, 2'b10, 32'h01020304);
      do_read("R11 new address", 8'h91, 2'b00, 32'h00000003);

      // R1 reset mid-run restores the image
      @(negedge clk);
      rst_n = 1'b0; addr = 8'h10; size = 2'b10;
      #1 check("R1 window after reset", rdata, 32'h0);
      check("R1 remap after reset", {31'h0, remap_pulse}, 32'h0);
      addr = 8'h80;
      #1 check("R1 device area after reset", rdata, 32'h0);
      addr = 8'h04;
      #1 check("R1 command after reset", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      do_read("R1 ROM after reset", 8'h30, 2'b10, 32'h0);
      finish_run();
   end
endmodule